// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles the control-flow outcome of one branch or jump instruction per valid cycle. From the instruction's address, two register operands, a 16-bit word offset, a 26-bit jump index and a decoded kind code, it works out four things. It decides whether control transfers. It forms the destination address. It decides whether a return address is written, and to which register. It also decides whether the instruction in the delay slot must be squashed.

The conditional kinds test either equality of the two operands or the sign and zero state of the first operand. Relative destinations are counted from the delay-slot address. Absolute jumps keep the upper address bits of the current instruction. Register jumps go to the first operand.

Linking kinds always produce a write of the address two instructions past the branch. A separate "likely" input turns on delay-slot cancellation for conditional kinds whose condition fails. All results appear together, registered, one cycle after the input is presented, and carry a valid flag.

Top module: `branch_resolve_unit`

## Requirements
- R1: Results are registered: `outValid` rises in the cycle after `inValid` is high. After a cycle with `inValid` low, `outValid`, `taken`, `linkWe` and `nullify` are 0. Reset (`rstN` low) clears every output to 0.
- R2: Kind 1 (equal) is taken when `rsVal == rtVal`, and kind 2 (not-equal) is taken when they differ. Equal with both operands zero, the unconditional-branch idiom, is therefore always taken.
- R3: Kinds 3 and 7 are taken when `rsVal[31]` is 0. Kinds 4 and 8 are taken when `rsVal[31]` is 1.
- R4: Kind 5 is taken when `rsVal[31]` is 0 and `rsVal` is nonzero. Kind 6 is taken when `rsVal[31]` is 1 or `rsVal` is zero.
- R5: For kinds 1 to 8, `targetPc` = `pc + 4 + (sign-extended offset << 2)`.
- R6: Kinds 7, 8 and 10 raise `linkWe` with `linkIdx` = 31 and `linkValue` = `pc + 8`, whether or not the transfer is taken.
- R7: `nullify` is 1 exactly when `likely` is 1, the kind is conditional (1 to 8) and its condition is false. It is 0 for all other kinds and whenever `taken` is 1.
- R8: Kinds 9 and 10 are always taken, with `targetPc` = {`pc[31:28]`, `jumpIndex`, 2'b00}.
- R9: Kinds 11 and 12 are always taken, with `targetPc` = `rsVal`. Kind 12 raises `linkWe` with `linkIdx` = `rdIdx` and `linkValue` = `pc + 8`.
- R10: Kind 0 and the unused codes 13 to 15 give `taken` = 0, `nullify` = 0 and `linkWe` = 0, even when `likely` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input fields hold an instruction to resolve |
| brType | input | 4 | Decoded kind code (see requirements) |
| likely | input | 1 | Cancel the delay slot when a conditional kind falls through |
| pc | input | 32 | Address of the branch instruction |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand |
| offset | input | 16 | Signed word offset for relative kinds |
| jumpIndex | input | 26 | Word index for absolute jumps |
| rdIdx | input | 5 | Link destination for register jump with link |
| outValid | output | 1 | Outputs below hold a resolved result |
| taken | output | 1 | Control transfers to `targetPc` |
| targetPc | output | 32 | Destination address |
| linkWe | output | 1 | Write `linkValue` to register `linkIdx` |
| linkIdx | output | 5 | Link register index |
| linkValue | output | 32 | Return address |
| nullify | output | 1 | Squash the delay-slot instruction |

## Verification
The corners that are hardest to reach are the sign and zero boundaries of the first operand, and the likely fall-through case. Cancellation must appear only when a conditional test fails with `likely` set. The bench sweeps every kind code, including the unused ones, against both `likely` values and every pair drawn from a set of operands. The set holds zero, one, all-ones, the most negative value, the most positive value and a small positive value. Each pair is tried with a forward and a backward offset and with two addresses whose upper nibbles differ. This reaches all true/false splits of each condition, equal-operand and zero cases among them, and the link-on-fall-through cases.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [3:0] {
    BR_NONE      = 4'd0,
    BR_EQ        = 4'd1,
    BR_NE        = 4'd2,
    BR_GEZ       = 4'd3,
    BR_LTZ       = 4'd4,
    BR_GTZ       = 4'd5,
    BR_LEZ       = 4'd6,
    BR_GEZ_LINK  = 4'd7,
    BR_LTZ_LINK  = 4'd8,
    JMP_ABS      = 4'd9,
    JMP_ABS_LINK = 4'd10,
    JMP_REG      = 4'd11,
    JMP_REG_LINK = 4'd12
  } brKind_e;

  typedef enum logic [2:0] {
    C_NEVER, C_ALWAYS, C_EQ, C_NE, C_GEZ, C_LTZ, C_GTZ, C_LEZ
  } condSel_e;

  typedef enum logic [1:0] {
    T_REL, T_ABS, T_REG
  } tgtSel_e;

  typedef struct packed {
    condSel_e cond;
    tgtSel_e  tgt;
    logic     likelyOn;
    logic     linkEn;
    logic     linkToRd;
  } brCtl_t;

endpackage

// File: rtl/br_ctrl.sv
module br_ctrl
  import br_pkg::*;
(
  input  logic [3:0] brType,
  input  logic       likely,
  output brCtl_t     ctl
);

  logic condKind;

  always_comb begin
    ctl      = '{cond: C_NEVER, tgt: T_REL, likelyOn: 1'b0, linkEn: 1'b0, linkToRd: 1'b0};
    condKind = 1'b0;
    case (brType)
      BR_EQ:        begin ctl.cond = C_EQ;  condKind = 1'b1; end
      BR_NE:        begin ctl.cond = C_NE;  condKind = 1'b1; end
      BR_GEZ:       begin ctl.cond = C_GEZ; condKind = 1'b1; end
      BR_LTZ:       begin ctl.cond = C_LTZ; condKind = 1'b1; end
      BR_GTZ:       begin ctl.cond = C_GTZ; condKind = 1'b1; end
      BR_LEZ:       begin ctl.cond = C_LEZ; condKind = 1'b1; end
      BR_GEZ_LINK:  begin ctl.cond = C_GEZ; condKind = 1'b1; ctl.linkEn = 1'b1; end
      BR_LTZ_LINK:  begin ctl.cond = C_LTZ; condKind = 1'b1; ctl.linkEn = 1'b1; end
      JMP_ABS:      begin ctl.cond = C_ALWAYS; ctl.tgt = T_ABS; end
      JMP_ABS_LINK: begin ctl.cond = C_ALWAYS; ctl.tgt = T_ABS; ctl.linkEn = 1'b1; end
      JMP_REG:      begin ctl.cond = C_ALWAYS; ctl.tgt = T_REG; end
      JMP_REG_LINK: begin
        ctl.cond = C_ALWAYS; ctl.tgt = T_REG; ctl.linkEn = 1'b1; ctl.linkToRd = 1'b1;
      end
      default: ;
    endcase
    ctl.likelyOn = likely & condKind;
  end

endmodule

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  brCtl_t            ctl,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IDX_W-1:0]  jumpIndex,
  input  logic [RIDX_W-1:0] rdIdx,
  output logic              outValid,
  output logic              taken,
  output logic [DATA_W-1:0] targetPc,
  output logic              linkWe,
  output logic [RIDX_W-1:0] linkIdx,
  output logic [DATA_W-1:0] linkValue,
  output logic              nullify
);

  localparam int EXT_W  = DATA_W - OFF_W - 2;
  localparam int HIGH_W = DATA_W - IDX_W - 2;

  logic              rsNeg, rsZero, opsEq, condHit;
  logic [DATA_W-1:0] relTgt, absTgt, tgtNext, seqPc;

  assign rsNeg  = rsVal[DATA_W-1];
  assign rsZero = (rsVal == '0);
  assign opsEq  = (rsVal == rtVal);

  always_comb begin
    case (ctl.cond)
      C_ALWAYS: condHit = 1'b1;
      C_EQ:     condHit = opsEq;
      C_NE:     condHit = ~opsEq;
      C_GEZ:    condHit = ~rsNeg;
      C_LTZ:    condHit = rsNeg;
      C_GTZ:    condHit = ~rsNeg & ~rsZero;
      C_LEZ:    condHit = rsNeg | rsZero;
      default:  condHit = 1'b0;
    endcase
  end

  assign seqPc  = pc + DATA_W'(4);
  assign relTgt = seqPc + {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign absTgt = {pc[DATA_W-1 -: HIGH_W], jumpIndex, 2'b00};

  always_comb begin
    case (ctl.tgt)
      T_ABS:   tgtNext = absTgt;
      T_REG:   tgtNext = rsVal;
      default: tgtNext = relTgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      taken     <= 1'b0;
      linkWe    <= 1'b0;
      nullify   <= 1'b0;
      targetPc  <= '0;
      linkIdx   <= '0;
      linkValue <= '0;
    end else begin
      outValid <= inValid;
      taken    <= inValid & condHit;
      linkWe   <= inValid & ctl.linkEn;
      nullify  <= inValid & ctl.likelyOn & ~condHit;
      if (inValid) begin
        targetPc  <= tgtNext;
        linkIdx   <= ctl.linkToRd ? rdIdx : RIDX_W'(LINK_REG);
        linkValue <= pc + DATA_W'(8);
      end
    end
  end

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import br_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OFF_W    = 16,
  parameter int IDX_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        brType,
  input  logic              likely,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IDX_W-1:0]  jumpIndex,
  input  logic [RIDX_W-1:0] rdIdx,
  output logic              outValid,
  output logic              taken,
  output logic [DATA_W-1:0] targetPc,
  output logic              linkWe,
  output logic [RIDX_W-1:0] linkIdx,
  output logic [DATA_W-1:0] linkValue,
  output logic              nullify
);

  brCtl_t ctl;

  br_ctrl u_ctrl (
    .brType (brType),
    .likely (likely),
    .ctl    (ctl)
  );

  br_datapath #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .ctl       (ctl),
    .pc        (pc),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .offset    (offset),
    .jumpIndex (jumpIndex),
    .rdIdx     (rdIdx),
    .outValid  (outValid),
    .taken     (taken),
    .targetPc  (targetPc),
    .linkWe    (linkWe),
    .linkIdx   (linkIdx),
    .linkValue (linkValue),
    .nullify   (nullify)
  );

endmodule

// File: rtl/br_checker.sv
module br_checker
  import br_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        brType,
  input logic              likely,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] rsVal,
  input logic [DATA_W-1:0] rtVal,
  input logic [OFF_W-1:0]  offset,
  input logic [IDX_W-1:0]  jumpIndex,
  input logic [RIDX_W-1:0] rdIdx,
  input logic              outValid,
  input logic              taken,
  input logic [DATA_W-1:0] targetPc,
  input logic              linkWe,
  input logic [RIDX_W-1:0] linkIdx,
  input logic [DATA_W-1:0] linkValue,
  input logic              nullify
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!taken && !linkWe && !nullify));

  assert_eq_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && brType == BR_EQ && rsVal == rtVal) |=> taken);

  assert_rel_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && brType == BR_NE && rsVal != rtVal) |=>
      (targetPc == $past(pc) + 4 + {{(DATA_W-OFF_W-2){$past(offset[OFF_W-1])}}, $past(offset), 2'b00}));

  assert_link_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkValue == $past(pc) + 8));

  assert_null_not_taken_R7: assert property (@(posedge clk) disable iff (!rstN)
    nullify |-> (!taken && $past(likely)));

  assert_abs_jump_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && brType == JMP_ABS) |=>
      (taken && targetPc == {$past(pc[DATA_W-1 -: DATA_W-IDX_W-2]), $past(jumpIndex), 2'b00}));

  assert_reg_link_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && brType == JMP_REG_LINK) |=>
      (taken && linkWe && linkIdx == $past(rdIdx) && targetPc == $past(rsVal)));

  assert_none_kind_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && brType == BR_NONE) |=> (!taken && !linkWe && !nullify));

endmodule

bind branch_resolve_unit br_checker #(
  .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .RIDX_W(RIDX_W)
) u_br_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .brType(brType), .likely(likely),
  .pc(pc), .rsVal(rsVal), .rtVal(rtVal), .offset(offset), .jumpIndex(jumpIndex),
  .rdIdx(rdIdx), .outValid(outValid), .taken(taken), .targetPc(targetPc),
  .linkWe(linkWe), .linkIdx(linkIdx), .linkValue(linkValue), .nullify(nullify)
);

// File: tb/test_branch_resolve_unit.sv
`timescale 1ns/1ps
module test_branch_resolve_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [3:0]  brType;
  logic        likely;
  logic [31:0] pc, rsVal, rtVal;
  logic [15:0] offset;
  logic [25:0] jumpIndex;
  logic [4:0]  rdIdx;
  logic        outValid, taken, linkWe, nullify;
  logic [31:0] targetPc, linkValue;
  logic [4:0]  linkIdx;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  branch_resolve_unit i_branch_resolve_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .brType(brType), .likely(likely),
    .pc(pc), .rsVal(rsVal), .rtVal(rtVal), .offset(offset), .jumpIndex(jumpIndex),
    .rdIdx(rdIdx), .outValid(outValid), .taken(taken), .targetPc(targetPc),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkValue(linkValue), .nullify(nullify)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string condReq(input int k);
    case (k)
      1, 2:          return "R2";
      3, 4, 7, 8:    return "R3";
      5, 6:          return "R4";
      9, 10:         return "R8";
      11, 12:        return "R9";
      default:       return "R10";
    endcase
  endfunction

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0005};

  task automatic runVector(input int k, input bit lk, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] p, input logic [15:0] off);
    bit expCond, expTaken, expNull, expLink, isCond;
    logic [4:0]  expIdx;
    logic [31:0] expTgt;
    string req;
    isCond  = (k >= 1 && k <= 8);
    case (k)
      1:       expCond = (a == b);
      2:       expCond = (a != b);
      3, 7:    expCond = !a[31];
      4, 8:    expCond = a[31];
      5:       expCond = !a[31] && a != 0;
      6:       expCond = a[31] || a == 0;
      9, 10, 11, 12: expCond = 1;
      default: expCond = 0;
    endcase
    expTaken = expCond;
    expNull  = lk && isCond && !expCond;
    expLink  = (k == 7 || k == 8 || k == 10 || k == 12);
    expIdx   = (k == 12) ? 5'd9 : 5'd31;
    if (isCond)       expTgt = p + 32'd4 + {{14{off[15]}}, off, 2'b00};
    else if (k <= 10) expTgt = {p[31:28], 26'h2AB_CDEF, 2'b00};
    else              expTgt = a;
    @(negedge clk);
    inValid = 1; brType = 4'(k); likely = lk; rsVal = a; rtVal = b; pc = p;
    offset = off; jumpIndex = 26'h2AB_CDEF; rdIdx = 5'd9;
    @(negedge clk);
    req = condReq(k);
    check("R1", "outValid", {31'b0, outValid}, 32'd1);
    check(req, $sformatf("taken kind %0d", k), {31'b0, taken}, {31'b0, expTaken});
    check(k > 12 || k == 0 ? "R10" : "R7", $sformatf("nullify kind %0d", k), {31'b0, nullify}, {31'b0, expNull});
    check(k == 12 ? "R9" : (k == 0 || k > 12 ? "R10" : "R6"), $sformatf("linkWe kind %0d", k),
          {31'b0, linkWe}, {31'b0, expLink});
    if (expLink) begin
      check(k == 12 ? "R9" : "R6", "linkIdx", {27'b0, linkIdx}, {27'b0, expIdx});
      check(k == 12 ? "R9" : "R6", "linkValue", linkValue, p + 32'd8);
    end
    if (expTaken)
      check(isCond ? "R5" : req, $sformatf("targetPc kind %0d", k), targetPc, expTgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; inValid = 0; brType = 0; likely = 0; pc = 0; rsVal = 0; rtVal = 0;
    offset = 0; jumpIndex = 0; rdIdx = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset outValid", {31'b0, outValid}, 32'd0);
    check("R1", "reset taken", {31'b0, taken}, 32'd0);
    check("R1", "reset targetPc", targetPc, 32'd0);
    check("R1", "reset linkValue", linkValue, 32'd0);
    rstN = 1;

    for (int k = 0; k < 16; k++)
      for (int lk = 0; lk < 2; lk++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++) begin
            runVector(k, lk[0], vals[i], vals[j], 32'h0040_1000, 16'h0003);
            runVector(k, lk[0], vals[i], vals[j], 32'hF000_0FFC, 16'hFFFE);
          end

    // R2: unconditional idiom (equal on zero against zero) with likely set
    runVector(1, 1'b1, 32'h0, 32'h0, 32'h1234_5670, 16'h8000);

    // R1: idle cycle clears strobes
    @(negedge clk);
    inValid = 0; brType = 4'd10; likely = 1;
    @(negedge clk);
    check("R1", "idle outValid", {31'b0, outValid}, 32'd0);
    check("R1", "idle taken", {31'b0, taken}, 32'd0);
    check("R1", "idle linkWe", {31'b0, linkWe}, 32'd0);
    check("R1", "idle nullify", {31'b0, nullify}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule